// File: doc/BRIEF.md
# Legacy I/O Configuration Port Controller

This block is the configuration front end of a multi-function legacy I/O controller on an 8-bit host I/O bus. The block starts locked. The host unlocks it by writing a fixed four-byte key to a configuration port. The last byte of the key also chooses where the index/data register pair is placed. Once the block is unlocked, the host writes a register number to the index address and then reads or writes that register at the address one above.

There are two kinds of registers. Global registers hold the device-number selector, the exit command, the controller select, the clock select and the suspend control. Per-device registers sit in banks, and the device-number selector picks which bank an access reaches. Each of the nine banks holds an activation bit, which drives one output enable line. Two such controllers can share the bus: a select bit is compared against a strap pin, and until that bit is first written, both controllers respond.

Top module: `cfg_port_ctrl`

## Requirements
- R1: After reset the block is locked. All `dev_en` bits are 0, `clk48_sel` is 0, `suspend` is 0, the device number is 0 and `chip_sel` is 1.
- R2: Four writes to port 0x2E with the bytes 0x87, 0x01, 0x55, 0x55 unlock the block and place the index register at 0x2E and the data register at 0x2F.
- R3: If the fourth key byte is 0xAA, the pair is placed at 0x4E/0x4F instead. Reads at 0x2E/0x2F then return 0xFF.
- R4: Any key byte that does not match sends the sequencer back to its first step. A mismatching 0x87 counts as the first byte of a new key.
- R5: While the block is locked, writes to the index/data addresses change nothing, and every read returns 0xFF.
- R6: A write to the index address sets the register number. A read at the index address returns that number. Data accesses act on the indexed register.
- R7: Register 0x07 holds the device number. A write to register 0x30 sets bit 0 of the selected device's activation bit, which appears on `dev_en[n]` from the next cycle. Device numbers 9 and above select no bank: writes to 0x30 are ignored and reads of 0x30 return 0x00.
- R8: Register 0x02 is write-only. Writing it with bit 1 set locks the block, and the full key is needed again. Writing it with bit 1 clear has no effect.
- R9: Register 0x22 bit 7 is compared with `strap_in`. `chip_sel` is 1 while 0x22 has never been written since reset, or while the two bits are equal. While `chip_sel` is 0, only data writes to 0x02 and 0x22 and index writes take effect, and reads return 0xFF.
- R10: Bit 0 of register 0x24 drives `clk48_sel` (1 selects 48 MHz). Bit 0 of register 0x23 drives `suspend`. Both read back in bit 0.
- R11: Reads of register 0x02 and of any register not listed here return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 16 | I/O port address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; 0xFF when the access is not claimed |
| strap_in | input | 1 | Strap that identifies this controller of a pair |
| dev_en | output | 9 | Per-device activation lines |
| clk48_sel | output | 1 | Input clock select: 0 for 24 MHz, 1 for 48 MHz |
| suspend | output | 1 | Software suspend control |
| chip_sel | output | 1 | This controller currently responds to accesses |

## Verification
The assertions assume that each write strobe marks one complete access that lasts a single cycle. They also assume that read and write strobes never overlap, and that the address and data are stable while a strobe is high. The stimulus drives every strobe for exactly one clock and never raises both strobes at once. It mixes addresses inside and outside the two index/data windows and key bytes with arbitrary data. That way, partial keys, exit commands and controller deselection all arise inside these limits.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  localparam int unsigned BYTE_W = 8;

  // Key bytes of the unlock sequence
  localparam logic [7:0] KEY_FIRST  = 8'h87;
  localparam logic [7:0] KEY_SECOND = 8'h01;
  localparam logic [7:0] KEY_THIRD  = 8'h55;
  localparam logic [7:0] KEY_LOW    = 8'h55;
  localparam logic [7:0] KEY_HIGH   = 8'hAA;

  // Register indices
  localparam logic [7:0] RIX_EXIT    = 8'h02;
  localparam logic [7:0] RIX_DEVNUM  = 8'h07;
  localparam logic [7:0] RIX_CHIPSEL = 8'h22;
  localparam logic [7:0] RIX_SUSP    = 8'h23;
  localparam logic [7:0] RIX_CLKSEL  = 8'h24;
  localparam logic [7:0] RIX_ACT     = 8'h30;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_GOT1 = 2'd1,
    SEQ_GOT2 = 2'd2,
    SEQ_GOT3 = 2'd3
  } seq_t;

  typedef struct packed {
    seq_t nxt;
    logic open;
    logic alt;
  } seq_step_t;

  // One step of the key matcher; a mismatch restarts, 0x87 re-arms
  function automatic seq_step_t seq_advance(seq_t cur, logic [7:0] b);
    seq_step_t r;
    r.open = 1'b0;
    r.alt  = 1'b0;
    r.nxt  = (b == KEY_FIRST) ? SEQ_GOT1 : SEQ_IDLE;
    case (cur)
      SEQ_GOT1: if (b == KEY_SECOND) r.nxt = SEQ_GOT2;
      SEQ_GOT2: if (b == KEY_THIRD)  r.nxt = SEQ_GOT3;
      SEQ_GOT3: if (b == KEY_LOW || b == KEY_HIGH) begin
        r.nxt  = SEQ_IDLE;
        r.open = 1'b1;
        r.alt  = (b == KEY_HIGH);
      end
      default: ;
    endcase
    return r;
  endfunction

  // Pair arbitration: both respond until the select register is written
  function automatic logic chip_responds(logic written, logic sel_bit, logic strap);
    return !written || (sel_bit == strap);
  endfunction

endpackage

// File: rtl/cfgp_unlock.sv
module cfgp_unlock
  import cfgp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic [BYTE_W-1:0] key_byte,
  input  logic             exit_hit,
  output logic             unlocked,
  output logic             alt_base,
  output logic             open_evt
);

  seq_t      step_q;
  seq_step_t adv;

  always_comb adv = seq_advance(step_q, key_byte);

  assign open_evt = key_wr && !unlocked && adv.open;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q   <= SEQ_IDLE;
      unlocked <= 1'b0;
      alt_base <= 1'b0;
    end else if (!unlocked) begin
      if (key_wr) begin
        step_q <= adv.nxt;
        if (adv.open) begin
          unlocked <= 1'b1;
          alt_base <= adv.alt;
        end
      end
    end else if (exit_hit) begin
      unlocked <= 1'b0;
      step_q   <= SEQ_IDLE;
    end
  end

endmodule

// File: rtl/cfgp_globals.sv
module cfgp_globals
  import cfgp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_we,
  input  logic              dat_we,
  input  logic              selected,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] index,
  output logic [BYTE_W-1:0] devnum,
  output logic              sel_written,
  output logic              sel_bit,
  output logic              clk48,
  output logic              susp,
  output logic              exit_hit
);

  logic hit_sel, hit_dev, hit_clk, hit_susp;

  // Exit and controller select act regardless of pair arbitration
  assign exit_hit = dat_we && (index == RIX_EXIT) && wdata[1];
  assign hit_sel  = dat_we && (index == RIX_CHIPSEL);
  assign hit_dev  = dat_we && selected && (index == RIX_DEVNUM);
  assign hit_clk  = dat_we && selected && (index == RIX_CLKSEL);
  assign hit_susp = dat_we && selected && (index == RIX_SUSP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index       <= '0;
      devnum      <= '0;
      sel_written <= 1'b0;
      sel_bit     <= 1'b0;
      clk48       <= 1'b0;
      susp        <= 1'b0;
    end else begin
      if (idx_we)   index  <= wdata;
      if (hit_dev)  devnum <= wdata;
      if (hit_clk)  clk48  <= wdata[0];
      if (hit_susp) susp   <= wdata[0];
      if (hit_sel) begin
        sel_written <= 1'b1;
        sel_bit     <= wdata[7];
      end
    end
  end

endmodule

// File: rtl/cfgp_dev_bank.sv
module cfgp_dev_bank
  import cfgp_pkg::*;
#(
  parameter int unsigned NUM_DEV = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_we,
  input  logic [BYTE_W-1:0] devnum,
  input  logic              act_in,
  output logic [NUM_DEV-1:0] act,
  output logic              cur_act
);

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    always_ff @(posedge clk) begin
      if (!rst_n)                                   act[g] <= 1'b0;
      else if (bank_we && devnum == BYTE_W'(g))     act[g] <= act_in;
    end
  end

  // Activation bit of the selected bank; 0 when no bank is selected
  always_comb begin
    cur_act = 1'b0;
    for (int i = 0; i < NUM_DEV; i++)
      if (devnum == BYTE_W'(i)) cur_act = act[i];
  end

endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cfgp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned NUM_DEV   = 9,
  parameter logic [15:0] CFG_PORT  = 16'h002E,
  parameter logic [15:0] BASE_PRI  = 16'h002E,
  parameter logic [15:0] BASE_ALT  = 16'h004E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              strap_in,
  output logic [NUM_DEV-1:0] dev_en,
  output logic              clk48_sel,
  output logic              suspend,
  output logic              chip_sel
);

  localparam logic [ADDR_W-1:0] PORT_A = ADDR_W'(CFG_PORT);
  localparam logic [ADDR_W-1:0] PRI_A  = ADDR_W'(BASE_PRI);
  localparam logic [ADDR_W-1:0] ALT_A  = ADDR_W'(BASE_ALT);

  logic              unlocked, alt_base, open_evt, exit_hit;
  logic [ADDR_W-1:0] base;
  logic              hit_idx, hit_dat;
  logic              idx_we, dat_we, bank_we, key_wr;
  logic [7:0]        index, devnum;
  logic              sel_written, sel_bit, cur_act;

  assign base    = alt_base ? ALT_A : PRI_A;
  assign hit_idx = (bus_addr == base);
  assign hit_dat = (bus_addr == base + ADDR_W'(1));
  assign key_wr  = bus_wr && (bus_addr == PORT_A);
  assign idx_we  = bus_wr && unlocked && hit_idx;
  assign dat_we  = bus_wr && unlocked && hit_dat;
  assign bank_we = dat_we && chip_sel && (index == RIX_ACT) && (devnum < 8'(NUM_DEV));
  assign chip_sel = chip_responds(sel_written, sel_bit, strap_in);

  cfgp_unlock u_unlock (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .key_byte (bus_wdata),
    .exit_hit (exit_hit),
    .unlocked (unlocked),
    .alt_base (alt_base),
    .open_evt (open_evt)
  );

  cfgp_globals u_glob (
    .clk         (clk),
    .rst_n       (rst_n),
    .idx_we      (idx_we),
    .dat_we      (dat_we),
    .selected    (chip_sel),
    .wdata       (bus_wdata),
    .index       (index),
    .devnum      (devnum),
    .sel_written (sel_written),
    .sel_bit     (sel_bit),
    .clk48       (clk48_sel),
    .susp        (suspend),
    .exit_hit    (exit_hit)
  );

  cfgp_dev_bank #(.NUM_DEV(NUM_DEV)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .bank_we (bank_we),
    .devnum  (devnum),
    .act_in  (bus_wdata[0]),
    .act     (dev_en),
    .cur_act (cur_act)
  );

  always_comb begin
    bus_rdata = 8'hFF;
    if (bus_rd && unlocked && chip_sel) begin
      if (hit_idx) bus_rdata = index;
      else if (hit_dat) begin
        case (index)
          RIX_DEVNUM:  bus_rdata = devnum;
          RIX_CHIPSEL: bus_rdata = {sel_bit, 7'b0};
          RIX_SUSP:    bus_rdata = {7'b0, suspend};
          RIX_CLKSEL:  bus_rdata = {7'b0, clk48_sel};
          RIX_ACT:     bus_rdata = {7'b0, cur_act};
          default:     bus_rdata = 8'h00;
        endcase
      end
    end
  end

endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned NUM_DEV  = 9,
  parameter logic [15:0] CFG_PORT = 16'h002E
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              unlocked,
  input logic              open_evt,
  input logic              exit_hit,
  input logic              sel_written,
  input logic              chip_sel,
  input logic [NUM_DEV-1:0] dev_en
);

  // R2: unlocking only follows a final key byte on the configuration port
  p_unlock_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(bus_wr && bus_addr == ADDR_W'(CFG_PORT) &&
                              (bus_wdata == 8'h55 || bus_wdata == 8'hAA)));

  // R2: the sequencer event always takes effect
  p_open_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    open_evt |=> unlocked);

  // R5: locked reads float high
  p_locked_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && bus_rd) |-> bus_rdata == 8'hFF);

  // R5: nothing changes device enables while locked
  p_locked_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(dev_en));

  // R7: one access changes at most one device enable
  p_one_dev_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dev_en ^ $past(dev_en)) <= 1);

  // R8: exit command locks on the next cycle
  p_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && exit_hit) |=> !unlocked);

  // R9: both controllers respond until the select register is written
  p_pair_default_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_written |-> chip_sel);

  // R9: a deselected controller never claims a read
  p_desel_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !chip_sel) |-> bus_rdata == 8'hFF);

endmodule

bind cfg_port_ctrl cfgp_checker #(
  .ADDR_W(ADDR_W), .NUM_DEV(NUM_DEV), .CFG_PORT(CFG_PORT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .unlocked    (unlocked),
  .open_evt    (open_evt),
  .exit_hit    (exit_hit),
  .sel_written (sel_written),
  .chip_sel    (chip_sel),
  .dev_en      (dev_en)
);

// File: tb/cfg_port_ctrl_bench.sv
module cfg_port_ctrl_bench;

  localparam int NDEV = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        strap_in = 1'b0;
  logic [NDEV-1:0] dev_en;
  logic        clk48_sel, suspend, chip_sel;

  int n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  cfg_port_ctrl u_cfg_port_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .strap_in(strap_in), .dev_en(dev_en), .clk48_sel(clk48_sel),
    .suspend(suspend), .chip_sel(chip_sel)
  );

  // Reference state, written from the requirements
  int          m_stage;
  bit          m_open, m_hi;
  logic [7:0]  m_ix, m_dn;
  bit          m_wr22, m_b22, m_c48, m_sus;
  bit [NDEV-1:0] m_on;

  function automatic bit m_sel();
    if (!m_wr22) return 1'b1;
    return m_b22 == strap_in;
  endfunction

  function automatic logic [15:0] m_base();
    return m_hi ? 16'h004E : 16'h002E;
  endfunction

  function automatic logic [7:0] m_read(logic [15:0] a);
    if (!m_open || !m_sel()) return 8'hFF;
    if (a == m_base()) return m_ix;
    if (a != m_base() + 16'd1) return 8'hFF;
    if (m_ix == 8'h07) return m_dn;
    if (m_ix == 8'h22) return m_b22 ? 8'h80 : 8'h00;
    if (m_ix == 8'h23) return {7'b0, m_sus};
    if (m_ix == 8'h24) return {7'b0, m_c48};
    if (m_ix == 8'h30 && m_dn < 8'(NDEV)) return {7'b0, m_on[m_dn]};
    return 8'h00;
  endfunction

  task automatic m_write(logic [15:0] a, logic [7:0] d);
    if (!m_open) begin
      if (a != 16'h002E) return;
      if (m_stage == 3 && (d == 8'h55 || d == 8'hAA)) begin
        m_open = 1; m_hi = (d == 8'hAA); m_stage = 0;
      end else if (m_stage == 1 && d == 8'h01) m_stage = 2;
      else if (m_stage == 2 && d == 8'h55) m_stage = 3;
      else m_stage = (d == 8'h87) ? 1 : 0;
    end else if (a == m_base()) m_ix = d;
    else if (a == m_base() + 16'd1) begin
      if (m_ix == 8'h02) begin
        if (d[1]) begin m_open = 0; m_stage = 0; end
      end else if (m_ix == 8'h22) begin
        m_wr22 = 1; m_b22 = d[7];
      end else if (m_sel()) begin
        case (m_ix)
          8'h07: m_dn = d;
          8'h23: m_sus = d[0];
          8'h24: m_c48 = d[0];
          8'h30: if (m_dn < 8'(NDEV)) m_on[m_dn] = d[0];
          default: ;
        endcase
      end
    end
  endtask

  task automatic m_reset();
    m_stage = 0; m_open = 0; m_hi = 0; m_ix = 0; m_dn = 0;
    m_wr22 = 0; m_b22 = 0; m_c48 = 0; m_sus = 0; m_on = '0;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_outs(string tag);
    check({tag, " dev_en"}, 32'(dev_en), 32'(m_on));
    check({tag, " clk48_sel"}, 32'(clk48_sel), 32'(m_c48));
    check({tag, " suspend"}, 32'(suspend), 32'(m_sus));
    check({tag, " chip_sel"}, 32'(chip_sel), 32'(m_sel()));
  endtask

  task automatic wr(string tag, logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    m_write(a, d);
    #1 check_outs(tag);
  endtask

  task automatic rd(string tag, logic [15:0] a);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 check({tag, " rdata"}, 32'(bus_rdata), 32'(m_read(a)));
    @(posedge clk);
    #1 bus_rd = 1'b0;
  endtask

  task automatic unlock(string tag, logic [7:0] last);
    wr(tag, 16'h2E, 8'h87); wr(tag, 16'h2E, 8'h01);
    wr(tag, 16'h2E, 8'h55); wr(tag, 16'h2E, last);
  endtask

  task automatic reg_wr(string tag, logic [7:0] ix, logic [7:0] d);
    wr(tag, m_base(), ix); wr(tag, m_base() + 16'd1, d);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1337));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 check_outs("R1 reset");
    rd("R1 R5 locked read", 16'h002F);

    // R5: locked writes have no effect
    wr("R5 locked", 16'h002F, 8'h30);
    wr("R5 locked", 16'h004F, 8'h01);
    rd("R5 locked read idx", 16'h002E);

    // R4: wrong byte restarts, 0x87 re-arms
    wr("R4", 16'h2E, 8'h87); wr("R4", 16'h2E, 8'h01); wr("R4", 16'h2E, 8'h33);
    wr("R4", 16'h2E, 8'h55); wr("R4", 16'h2E, 8'h55);
    rd("R4 still locked", 16'h002F);
    check("R4 model locked", 32'(m_open), 32'd0);
    wr("R4", 16'h2E, 8'h87); wr("R4", 16'h2E, 8'h01); wr("R4", 16'h2E, 8'h87);
    wr("R4", 16'h2E, 8'h01); wr("R4", 16'h2E, 8'h55); wr("R4", 16'h2E, 8'h55);
    check("R4 R2 model open", 32'(m_open), 32'd1);

    // R2, R6: index readback at 0x2E
    wr("R6", 16'h2E, 8'h5A);
    rd("R2 R6 index readback", 16'h002E);

    // R7: banked activation
    reg_wr("R7", 8'h07, 8'h03); reg_wr("R7", 8'h30, 8'h01);
    check("R7 dev3", 32'(dev_en), 32'h008);
    rd("R7 act read", 16'h002F);
    reg_wr("R7", 8'h07, 8'h08); reg_wr("R7", 8'h30, 8'hFF);
    reg_wr("R7", 8'h07, 8'h0C); reg_wr("R7", 8'h30, 8'h01);
    check("R7 out-of-range ignored", 32'(dev_en), 32'h108);
    rd("R7 out-of-range read", 16'h002F);

    // R10: clock select and suspend
    reg_wr("R10", 8'h24, 8'h01); reg_wr("R10", 8'h23, 8'h01);
    rd("R10 suspend read", 16'h002F);
    check("R10 clk48", 32'(clk48_sel), 32'd1);

    // R11: write-only and unimplemented reads
    wr("R11", 16'h2E, 8'h02); rd("R11 exit reg read", 16'h002F);
    wr("R11", 16'h2E, 8'h51); rd("R11 unimpl read", 16'h002F);

    // R9: controller select against strap
    strap_in = 1'b1;
    reg_wr("R9", 8'h22, 8'h00);
    check("R9 deselected", 32'(chip_sel), 32'd0);
    rd("R9 desel read", 16'h002F);
    reg_wr("R9", 8'h24, 8'h00);
    check("R9 ignored write", 32'(clk48_sel), 32'd1);
    reg_wr("R9", 8'h22, 8'h80);
    check("R9 reselected", 32'(chip_sel), 32'd1);

    // R8: exit only with bit 1
    reg_wr("R8", 8'h02, 8'hFD);
    rd("R8 still open", 16'h002E);
    reg_wr("R8", 8'h02, 8'h02);
    check("R8 model closed", 32'(m_open), 32'd0);
    rd("R8 closed read", 16'h002E);

    // R3: alternate base
    unlock("R3", 8'hAA);
    rd("R3 old base", 16'h002F);
    wr("R3", 16'h4E, 8'h07);
    rd("R3 new base", 16'h004F);

    // Random phase
    for (int blk = 0; blk < 40; blk++) begin
      if ($urandom % 3 != 0) unlock("R2 rnd", ($urandom % 2) ? 8'hAA : 8'h55);
      strap_in = 1'($urandom % 2);
      for (int k = 0; k < 50; k++) begin
        logic [15:0] a;
        logic [7:0]  d;
        case ($urandom % 5)
          0: a = 16'h2E; 1: a = 16'h2F; 2: a = 16'h4E; 3: a = 16'h4F;
          default: a = 16'h80;
        endcase
        case ($urandom % 12)
          0: d = 8'h87; 1: d = 8'h01; 2: d = 8'h55; 3: d = 8'hAA;
          4: d = 8'h07; 5: d = 8'h30; 6: d = 8'h02; 7: d = 8'h22;
          8: d = 8'h23; 9: d = 8'h24; 10: d = 8'($urandom % 12);
          default: d = 8'($urandom);
        endcase
        if ($urandom % 10 < 6) wr("R7 R9 R10 rnd", a, d);
        else rd("R6 R11 rnd", a);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule